// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Interface

This block is the digital front end of a two-channel 12-bit converter. A host writes it through a three-wire serial port. The three wires are a serial clock, a serial data line and an active-low select. The select also works as the load strobe. Each frame is a single 24-bit word that holds both channel codes back to back. The bits shift into an input register on rising serial-clock edges, and only while select is low. When select returns high, the input register is copied into both channel holding registers in the same cycle. The two 12-bit holding registers drive the parallel code outputs.

The far end of the input register is brought out as a serial data output. Several devices can therefore share one select line, with each device's output feeding the next device's data input. An active-low clear input forces both holding registers to zero. A synchronous active-high reset does the same and also empties the input register. Everything runs on one system clock. The serial clock, data, select and clear inputs each pass through two-flop synchronisers, and edge detection follows. The system clock must run at least four times faster than the serial clock.

Top module: `dual_dac_serial_if`

## Requirements
- R1: While and after reset, both code outputs and the serial output are zero.
- R2: After a frame ends, the first 12 bits shifted in appear on code_a_o and the next 12 bits appear on code_b_o. Both fields are sent most significant bit first, and both outputs change in the same system cycle.
- R3: The code outputs stay unchanged while bits are shifting. They change only when select rises or when clear is applied.
- R4: Serial clock edges that arrive while select is high shift nothing. A later select pulse with no clocks reloads the earlier contents.
- R5: sdo_o carries the oldest bit of the 24-bit input register and advances one bit per accepted rising edge. A frame shifted in therefore leaves the port MSB first while the next frame enters.
- R6: While clear is held low, both codes read zero within three system cycles. The input register is not disturbed by clear.
- R7: The frame length is not checked. A load takes the last 24 bits shifted in, including bits left over from an earlier frame.
- R8: A select rise that occurs while clear is low loads nothing. The codes stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| csn_i | input | 1 | Active-low select; rising edge loads |
| clr_n_i | input | 1 | Active-low clear of both channels |
| sdo_o | output | 1 | Serial data out for chaining |
| code_a_o | output | 12 | Channel A code |
| code_b_o | output | 12 | Channel B code |

## Verification
A corrupted input register does not show on the codes until the next select rise. It is visible sooner on sdo_o, which the bench compares bit by bit against the earlier frame while a new one is being clocked in. A missing select gate or a wrong shift direction shows as swapped or offset channel fields three cycles after select rises. A clear that fails to win over a load, or that disturbs the input register, shows in the codes read back once clear is released and select is pulsed again.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
  localparam int CODE_W = 12;
  localparam int NCH    = 2;
  localparam int FRAME_W = CODE_W * NCH;
endpackage

// File: rtl/in_sync.sv
module in_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= INIT[i];
        s2 <= INIT[i];
        s3 <= INIT[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign q[i]      = s2;
    assign q_prev[i] = s3;
  end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [FW-1:0] frame,
  output logic          tail
);
  logic [FW-1:0] sr;
  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else if (shift_en) sr <= {sr[FW-2:0], bit_in};
  end
  assign frame = sr;
  assign tail  = sr[FW-1];
endmodule

// File: rtl/hold_regs.sv
module hold_regs #(
  parameter int CW  = 12,
  parameter int NC  = 2,
  localparam int FW = CW * NC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          load,
  input  logic [FW-1:0] frame,
  output logic [FW-1:0] codes
);
  for (genvar c = 0; c < NC; c++) begin : g_ch
    logic [CW-1:0] r;
    always_ff @(posedge clk) begin
      if (rst || clear) r <= '0;
      else if (load)    r <= frame[c*CW +: CW];
    end
    assign codes[c*CW +: CW] = r;
  end
endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if
  import dac_if_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              csn_i,
  input  logic              clr_n_i,
  output logic              sdo_o,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o
);
  // synchronised vector: {clr_n, csn, sdi, sclk}
  logic [3:0] s_now, s_prev;

  in_sync #(.W(4), .INIT(4'b1100)) u_sync (
    .clk(clk), .rst(rst),
    .d({clr_n_i, csn_i, sdi_i, sclk_i}),
    .q(s_now), .q_prev(s_prev)
  );

  logic sclk_rise, cs_rise, shift_en, clear;
  assign sclk_rise = s_now[0] & ~s_prev[0];
  assign cs_rise   = s_now[2] & ~s_prev[2];
  assign shift_en  = sclk_rise & ~s_now[2];
  assign clear     = ~s_now[3];

  logic [FRAME_W-1:0] frame;
  logic               tail;

  frame_shifter #(.FW(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .bit_in(s_now[1]),
    .frame(frame), .tail(tail)
  );

  logic [FRAME_W-1:0] codes;

  hold_regs #(.CW(CODE_W), .NC(NCH)) u_hold (
    .clk(clk), .rst(rst), .clear(clear), .load(cs_rise),
    .frame(frame), .codes(codes)
  );

  assign sdo_o    = tail;
  assign code_a_o = codes[CODE_W +: CODE_W];
  assign code_b_o = codes[0 +: CODE_W];
endmodule

// File: rtl/dual_dac_serial_if_chk.sv
module dual_dac_serial_if_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          csn_i,
  input logic          clr_n_i,
  input logic          sdo_o,
  input logic [CW-1:0] code_a_o,
  input logic [CW-1:0] code_b_o
);
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (code_a_o == '0 && code_b_o == '0 && sdo_o == 1'b0));

  a_r6_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (!clr_n_i && $past(!clr_n_i) && $past(!clr_n_i, 2) && $past(!clr_n_i, 3))
    |-> (code_a_o == '0 && code_b_o == '0));

  a_r3_codes_hold: assert property (@(posedge clk) disable iff (rst)
    (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3) && $past(csn_i, 4)
     && clr_n_i && $past(clr_n_i) && $past(clr_n_i, 2) && $past(clr_n_i, 3) && $past(clr_n_i, 4))
    |-> ($stable(code_a_o) && $stable(code_b_o)));

  a_r4_sdo_idle: assert property (@(posedge clk) disable iff (rst)
    (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3)) |-> $stable(sdo_o));
endmodule

bind dual_dac_serial_if dual_dac_serial_if_chk #(.CW(dac_if_pkg::CODE_W)) u_chk (
  .clk(clk), .rst(rst), .csn_i(csn_i), .clr_n_i(clr_n_i),
  .sdo_o(sdo_o), .code_a_o(code_a_o), .code_b_o(code_b_o)
);

// File: tb/sim_dual_dac_serial_if.sv
module sim_dual_dac_serial_if;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  // {frame, expected A, expected B}
  localparam logic [47:0] VEC [NV] = '{
    {24'hABC123, 12'hABC, 12'h123},
    {24'hFFF000, 12'hFFF, 12'h000},
    {24'h000FFF, 12'h000, 12'hFFF},
    {24'h800001, 12'h800, 12'h001},
    {24'h5A5A5A, 12'h5A5, 12'hA5A}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, sdi = 1'b0, csn = 1'b1, clr_n = 1'b1;
  logic sdo;
  logic [11:0] ca, cb;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_serial_if u0 (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdi_i(sdi), .csn_i(csn),
    .clr_n_i(clr_n), .sdo_o(sdo), .code_a_o(ca), .code_b_o(cb)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // shift n bits (MSB of the n-bit field first); optionally check sdo against prev
  task automatic shift_bits(input logic [31:0] bits, input int n,
                            input bit sdo_chk, input logic [23:0] prev);
    for (int k = 0; k < n; k++) begin
      sdi = bits[n-1-k];
      sclk = 1'b0;
      wait_cyc(4);
      if (sdo_chk) chk("R5 sdo", {31'b0, sdo}, {31'b0, prev[23-k]});
      sclk = 1'b1;
      wait_cyc(4);
    end
    sclk = 1'b0;
  endtask

  task automatic send(input logic [31:0] bits, input int n,
                      input bit sdo_chk, input logic [23:0] prev);
    csn = 1'b0;
    wait_cyc(4);
    shift_bits(bits, n, sdo_chk, prev);
    wait_cyc(4);
    csn = 1'b1;
    wait_cyc(6);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(5);
    chk("R1 reset codes", {8'b0, ca, cb}, 32'h0);
    chk("R1 reset sdo", {31'b0, sdo}, 32'h0);
    rst = 1'b0;
    wait_cyc(4);
    chk("R1 after reset", {7'b0, sdo, ca, cb}, 32'h0);

    // R2 table walk
    for (int v = 0; v < NV; v++) begin
      send({8'b0, VEC[v][47:24]}, 24, 1'b0, 24'h0);
      chk("R2 channel A", {20'b0, ca}, {20'b0, VEC[v][23:12]});
      chk("R2 channel B", {20'b0, cb}, {20'b0, VEC[v][11:0]});
    end

    // R5: new frame pushes last frame (5A5A5A) out MSB first; R3: codes hold mid-frame
    csn = 1'b0;
    wait_cyc(4);
    shift_bits(32'h00123456 >> 12, 12, 1'b1, 24'h5A5A5A);
    chk("R3 hold mid-frame", {8'b0, ca, cb}, 32'h005A5A5A);
    shift_bits(32'h456, 12, 1'b0, 24'h0);
    wait_cyc(4);
    csn = 1'b1;
    wait_cyc(6);
    chk("R2 second frame", {8'b0, ca, cb}, 32'h00123456);

    // R4: clocks with select high ignored
    shift_bits(32'hFFFF, 16, 1'b0, 24'h0);
    wait_cyc(4);
    chk("R4 no load while high", {8'b0, ca, cb}, 32'h00123456);
    send(32'h0, 0, 1'b0, 24'h0);
    chk("R4 reload unchanged", {8'b0, ca, cb}, 32'h00123456);

    // R6: clear forces zero, shift register kept
    clr_n = 1'b0;
    wait_cyc(4);
    chk("R6 clear zero", {8'b0, ca, cb}, 32'h0);
    clr_n = 1'b1;
    wait_cyc(4);
    chk("R6 stays zero after release", {8'b0, ca, cb}, 32'h0);
    send(32'h0, 0, 1'b0, 24'h0);
    chk("R6 shift reg undisturbed", {8'b0, ca, cb}, 32'h00123456);

    // R7: long frame keeps last 24 bits; short frame mixes with old bits
    send(32'h9ABCDEF1, 28, 1'b0, 24'h0);
    chk("R7 long frame", {8'b0, ca, cb}, 32'h00BCDEF1);
    send(32'h00000777, 12, 1'b0, 24'h0);
    chk("R7 short frame", {8'b0, ca, cb}, 32'h00EF1777);

    // R8: select rises while clear low
    send(32'h00AAA555, 24, 1'b0, 24'h0);
    csn = 1'b0;
    wait_cyc(4);
    shift_bits(32'h00C3C3C3, 24, 1'b0, 24'h0);
    clr_n = 1'b0;
    wait_cyc(4);
    csn = 1'b1;
    wait_cyc(6);
    chk("R8 clear beats load", {8'b0, ca, cb}, 32'h0);
    clr_n = 1'b1;
    wait_cyc(6);
    chk("R8 still zero after clear", {8'b0, ca, cb}, 32'h0);

    // R1: reset mid-operation
    rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(2);
    chk("R1 reset again", {7'b0, sdo, ca, cb}, 32'h0);
    send(32'h0, 0, 1'b0, 24'h0);
    chk("R1 shift reg emptied", {8'b0, ca, cb}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule